// File: doc/BRIEF.md
# Supervisor Power-On and Sequence-Arming Controller

This block is the start-up controller of a multichannel voltage supervisor. When reset is released it can run a fixed-length self-test, depending on a strap input. It then reads a set of configuration words from a one-time-programmable store. Each word passes through a single-error-correcting, double-error-detecting check. Until both of these steps have finished, the host register port stays dead and the active-low interrupt stays released. Once they are done, the host can read the outcome in a status register. It can also take an interrupt for self-test completion and for an uncorrectable configuration error.

After start-up the block watches two board signals, ACT and SLEEP. Each passes through a two-flop synchronizer. A rising edge on ACT starts a sequence-timeout timer, counted in ticks of a fixed prescaled clock. The timer's length is a host-programmable register. While the timer runs, SLEEP edges have no effect. Once it expires with ACT still high, the block is armed. From then on, each SLEEP rising edge marks the start of sleep-entry monitoring and each falling edge the start of sleep-exit monitoring.

Top module: `pwr_arm_ctrl`

## Requirements
- R1: With `test_at_por`=1 the self-test runs for BIST_CYCLES cycles, then sets status bit 0 (done); status bit 1 (fail) is set if `st_fault` was high in any self-test cycle. With `test_at_por`=0 the self-test is skipped: status bit 4 (skipped) is set and bit 0 stays 0.
- R2: Until the configuration load has finished, `host_en` is 0, `reg_rdata` reads 0, host writes change no register, and `irq_n` stays 1.
- R3: Each stored word is a 13-bit code. Bit 0 is even parity over bits 12:1. Positions 1, 2, 4 and 8 hold the Hamming parity of the positions whose index has that bit set. Data bits d0..d7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. A single flipped bit is corrected, and the corrected byte of word i appears at `cfg_out[8*i+7:8*i]`.
- R4: A word with a double error keeps its byte of CFG_DEFAULT and sets status bit 3 (uncorrectable) and interrupt flag bit 1. Any corrected word sets status bit 2.
- R5: Interrupt flag register (address 1): bit 0 is set when the self-test completes, and bit 1 is set as in R4. Flags are sticky and are cleared by writing 1 to them.
- R6: `irq_n` is 0 exactly when the load has finished and some flag bit is set together with its bit in the enable register (address 2, reset 0). It follows a register change by one cycle.
- R7: After the load, a synchronized ACT rising edge raises `seq_mon` and starts the timer. Once the number of PRESCALE-cycle ticks held in register 3 has passed, with a value of 0 treated as 1, `armed` rises and `seq_mon` falls.
- R8: If ACT falls while the timer runs, the timer is cancelled: `seq_mon` drops, `armed` stays 0 and the block waits for the next ACT rising edge.
- R9: While the block is not armed, SLEEP edges produce no pulse. While armed, a SLEEP rising edge gives a one-cycle `slp_enter` pulse and a falling edge gives a one-cycle `slp_exit` pulse. ACT low leaves the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_at_por | input | 1 | Strap: run self-test after reset |
| st_fault | input | 1 | Self-test fault indication during the test |
| otp_rd | output | 1 | Configuration store read strobe |
| otp_addr | output | ADDR_W | Configuration word index |
| otp_word | input | 13 | Code word, valid the cycle after `otp_rd` |
| cfg_out | output | 8*N_WORDS | Loaded configuration bytes |
| host_en | output | 1 | Host register port enabled |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| irq_n | output | 1 | Active-low interrupt |
| act | input | 1 | Asynchronous ACT input |
| sleep | input | 1 | Asynchronous SLEEP input |
| seq_mon | output | 1 | Power-on sequence timer running |
| armed | output | 1 | Timeout expired with ACT high |
| slp_enter | output | 1 | Sleep-entry monitoring start pulse |
| slp_exit | output | 1 | Sleep-exit monitoring start pulse |

## Verification
The assertions check on every cycle that a host write while the port is disabled changes nothing, and that the interrupt is never low before the load has finished. They also check that flags stay set without a clearing write, that sleep pulses only come from the armed state, that ACT low cancels a running timer, and that the skipped and done bits are never both set. Whether corrected bytes and defaults land in the right place, and when the timer expires for a given register value, can only be seen in the bench's scenarios. The same holds for the status encodings after each reset path and for an interrupt that follows enable and clear writes.

// File: rtl/pwr_arm_pkg.sv
// Shared types for the supervisor power-on controller.
// Assumes an 8-bit data byte protected by a 13-bit SEC-DED code.
package pwr_arm_pkg;
    localparam int DW = 8;
    localparam int CW = 13;

    typedef enum logic [2:0] {B_START, B_TEST, B_REQ, B_CHK, B_RUN} boot_st_t;
    typedef enum logic [1:0] {Q_WAIT, Q_TIME, Q_ARMED} seq_st_t;

    // Status layout, bit 0 first: done, fail, corrected, uncorrectable, skipped
    typedef struct packed {
        logic skipped;
        logic unc;
        logic cor;
        logic fail;
        logic done;
    } tinfo_t;
endpackage

// File: rtl/dual_sync.sv
// Two-flop synchronizer with edge detection for W asynchronous inputs.
// Assumes inputs are slow compared with clk; rise/fall are one-cycle pulses.
module dual_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    // Synchronizer chain plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Per-bit edge decode
    for (genvar g = 0; g < W; g++) begin : g_edge
        assign rise[g] = s2_q[g] & ~s3_q[g];
        assign fall[g] = ~s2_q[g] & s3_q[g];
    end
    assign lvl = s2_q;
endmodule

// File: rtl/secded_chk.sv
// Combinational SEC-DED decoder for one 13-bit configuration word.
// Assumes bit 0 is overall even parity and bits 12:1 form a Hamming code.
module secded_chk
    import pwr_arm_pkg::*;
(
    input  logic [CW-1:0] code,
    output logic [DW-1:0] data,
    output logic          cor,
    output logic          unc
);
    logic [3:0]    syn;
    logic          ovp;
    logic [CW-1:0] fixed;

    // Syndrome, overall parity and single-bit repair
    always_comb begin
        syn = '0;
        for (int p = 1; p < CW; p++) begin
            if (code[p]) syn = syn ^ 4'(p);
        end
        ovp   = ^code;
        fixed = code;
        cor   = 1'b0;
        unc   = 1'b0;
        if (ovp) begin
            if (syn == 4'd0) begin
                cor = 1'b1;
            end else if (syn < 4'(CW)) begin
                fixed[syn] = ~fixed[syn];
                cor = 1'b1;
            end else begin
                unc = 1'b1;
            end
        end else if (syn != 4'd0) begin
            unc = 1'b1;
        end
        data = {fixed[12], fixed[11], fixed[10], fixed[9],
                fixed[7], fixed[6], fixed[5], fixed[3]};
    end
endmodule

// File: rtl/boot_seq.sv
// Start-up sequencer: optional self-test, then configuration load through
// the SEC-DED checker. Assumes the store returns data one cycle after a read.
module boot_seq
    import pwr_arm_pkg::*;
#(
    parameter int              N_WORDS     = 4,
    parameter int              BIST_CYCLES = 16,
    parameter logic [N_WORDS*DW-1:0] CFG_DEFAULT = '0,
    parameter int              ADDR_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  test_at_por,
    input  logic                  st_fault,
    output logic                  otp_rd,
    output logic [ADDR_W-1:0]     otp_addr,
    input  logic [CW-1:0]         otp_word,
    output logic [N_WORDS*DW-1:0] cfg_out,
    output tinfo_t                tinfo,
    output logic                  done_p,
    output logic                  unc_p,
    output logic                  boot_done
);
    localparam int CNTW = $clog2(BIST_CYCLES + 1);

    boot_st_t           st;
    logic [CNTW-1:0]    cnt_q;
    logic [ADDR_W-1:0]  idx_q;
    logic [DW-1:0]      cfg_q [N_WORDS];
    logic [DW-1:0]      dec_data;
    logic               dec_cor, dec_unc;

    secded_chk u_chk (
        .code (otp_word),
        .data (dec_data),
        .cor  (dec_cor),
        .unc  (dec_unc)
    );

    // Start-up state machine, status capture and configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= B_START;
            cnt_q  <= '0;
            idx_q  <= '0;
            tinfo  <= '0;
            done_p <= 1'b0;
            unc_p  <= 1'b0;
            for (int i = 0; i < N_WORDS; i++) cfg_q[i] <= CFG_DEFAULT[i*DW +: DW];
        end else begin
            done_p <= 1'b0;
            unc_p  <= 1'b0;
            case (st)
                B_START: begin
                    if (test_at_por) begin
                        st    <= B_TEST;
                        cnt_q <= '0;
                    end else begin
                        tinfo.skipped <= 1'b1;
                        st <= B_REQ;
                    end
                end
                B_TEST: begin
                    if (st_fault) tinfo.fail <= 1'b1;
                    if (cnt_q == CNTW'(BIST_CYCLES - 1)) begin
                        tinfo.done <= 1'b1;
                        done_p     <= 1'b1;
                        st         <= B_REQ;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                B_REQ: st <= B_CHK;
                B_CHK: begin
                    if (dec_unc) begin
                        tinfo.unc <= 1'b1;
                        unc_p     <= 1'b1;
                    end else begin
                        cfg_q[idx_q] <= dec_data;
                        if (dec_cor) tinfo.cor <= 1'b1;
                    end
                    if (idx_q == ADDR_W'(N_WORDS - 1)) begin
                        st <= B_RUN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        st    <= B_REQ;
                    end
                end
                default: st <= B_RUN;
            endcase
        end
    end

    // Read strobe and flattened configuration view
    assign otp_rd    = (st == B_REQ);
    assign otp_addr  = idx_q;
    assign boot_done = (st == B_RUN);
    for (genvar g = 0; g < N_WORDS; g++) begin : g_cfg
        assign cfg_out[g*DW +: DW] = cfg_q[g];
    end

    assert_skip_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(tinfo.skipped && tinfo.done));
    assert_no_read_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        otp_rd |-> !boot_done);
    assert_cor_unc_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == B_CHK) |-> !(dec_cor && dec_unc));
    assert_unc_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unc_p |-> tinfo.unc);
endmodule

// File: rtl/seq_arm.sv
// Sequence-arming machine: ACT rise starts a prescaled timeout; SLEEP edges
// are acted on only after expiry with ACT still high. Inputs are synchronized.
module seq_arm
    import pwr_arm_pkg::*;
#(
    parameter int PRESCALE = 8,
    parameter int TMO_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             act_lvl,
    input  logic             act_rise,
    input  logic             slp_rise,
    input  logic             slp_fall,
    input  logic [TMO_W-1:0] tmo,
    output logic             seq_mon,
    output logic             armed,
    output logic             slp_enter,
    output logic             slp_exit
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    seq_st_t          st;
    logic [PW-1:0]    pcnt_q;
    logic [TMO_W-1:0] tcnt_q;
    logic             tick;
    logic             expire;

    assign tick   = (pcnt_q == PW'(PRESCALE - 1));
    assign expire = ({1'b0, tcnt_q} + 1'b1) >= {1'b0, tmo};

    // Timer, arming state and sleep edge pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= Q_WAIT;
            pcnt_q    <= '0;
            tcnt_q    <= '0;
            slp_enter <= 1'b0;
            slp_exit  <= 1'b0;
        end else begin
            slp_enter <= 1'b0;
            slp_exit  <= 1'b0;
            case (st)
                Q_WAIT: begin
                    if (enable && act_rise) begin
                        st     <= Q_TIME;
                        pcnt_q <= '0;
                        tcnt_q <= '0;
                    end
                end
                Q_TIME: begin
                    if (!act_lvl) begin
                        st <= Q_WAIT;
                    end else begin
                        pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
                        if (tick) begin
                            if (expire) st <= Q_ARMED;
                            else        tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                Q_ARMED: begin
                    if (!act_lvl) begin
                        st <= Q_WAIT;
                    end else begin
                        slp_enter <= slp_rise;
                        slp_exit  <= slp_fall;
                    end
                end
                default: st <= Q_WAIT;
            endcase
        end
    end

    assign seq_mon = (st == Q_TIME);
    assign armed   = (st == Q_ARMED);

    assert_wait_not_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == Q_WAIT) |=> (st != Q_ARMED));
    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == Q_TIME && !act_lvl) |=> (st == Q_WAIT));
    assert_sleep_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slp_enter || slp_exit) |-> $past(st == Q_ARMED));
    assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(slp_enter && slp_exit));
endmodule

// File: rtl/pwr_arm_ctrl.sv
// Top of the supervisor power-on controller: start-up sequencer, host
// registers with sticky interrupt flags, and the sequence-arming machine.
// Assumes TMO_W <= 8 so the timeout fits one host register.
module pwr_arm_ctrl
    import pwr_arm_pkg::*;
#(
    parameter int N_WORDS     = 4,
    parameter int BIST_CYCLES = 16,
    parameter int PRESCALE    = 8,
    parameter int TMO_W       = 8,
    parameter int TMO_DEF     = 4,
    parameter logic [N_WORDS*8-1:0] CFG_DEFAULT = 32'hA5C3_5A3C,
    parameter int ADDR_W      = $clog2(N_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 test_at_por,
    input  logic                 st_fault,
    output logic                 otp_rd,
    output logic [ADDR_W-1:0]    otp_addr,
    input  logic [12:0]          otp_word,
    output logic [N_WORDS*8-1:0] cfg_out,
    output logic                 host_en,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic                 irq_n,
    input  logic                 act,
    input  logic                 sleep,
    output logic                 seq_mon,
    output logic                 armed,
    output logic                 slp_enter,
    output logic                 slp_exit
);
    localparam logic [1:0] A_STAT = 2'd0;
    localparam logic [1:0] A_FLAG = 2'd1;
    localparam logic [1:0] A_IEN  = 2'd2;
    localparam logic [1:0] A_TMO  = 2'd3;

    tinfo_t           tinfo;
    logic             done_p, unc_p, boot_done;
    logic [1:0]       flg_q, ien_q, flg_set, flg_clr;
    logic [TMO_W-1:0] tmo_q;
    logic             irq_q;
    logic             wr_ok;
    logic [1:0]       s_lvl, s_rise, s_fall;

    boot_seq #(
        .N_WORDS     (N_WORDS),
        .BIST_CYCLES (BIST_CYCLES),
        .CFG_DEFAULT (CFG_DEFAULT),
        .ADDR_W      (ADDR_W)
    ) u_boot (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_at_por (test_at_por),
        .st_fault    (st_fault),
        .otp_rd      (otp_rd),
        .otp_addr    (otp_addr),
        .otp_word    (otp_word),
        .cfg_out     (cfg_out),
        .tinfo       (tinfo),
        .done_p      (done_p),
        .unc_p       (unc_p),
        .boot_done   (boot_done)
    );

    dual_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sleep, act}),
        .lvl   (s_lvl),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    seq_arm #(
        .PRESCALE (PRESCALE),
        .TMO_W    (TMO_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (boot_done),
        .act_lvl   (s_lvl[0]),
        .act_rise  (s_rise[0]),
        .slp_rise  (s_rise[1]),
        .slp_fall  (s_fall[1]),
        .tmo       (tmo_q),
        .seq_mon   (seq_mon),
        .armed     (armed),
        .slp_enter (slp_enter),
        .slp_exit  (slp_exit)
    );

    assign host_en = boot_done;
    assign wr_ok   = reg_wr && host_en;
    assign flg_set = {unc_p, done_p};
    assign flg_clr = (wr_ok && reg_addr == A_FLAG) ? reg_wdata[1:0] : 2'b00;

    // Host registers: sticky flags with write-1-clear, enables, timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
            ien_q <= '0;
            tmo_q <= TMO_W'(TMO_DEF);
        end else begin
            flg_q <= (flg_q & ~flg_clr) | flg_set;
            if (wr_ok && reg_addr == A_IEN) ien_q <= reg_wdata[1:0];
            if (wr_ok && reg_addr == A_TMO) tmo_q <= reg_wdata[TMO_W-1:0];
        end
    end

    // Registered active-low interrupt, held released until load is done
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b1;
        else        irq_q <= !(host_en && |(flg_q & ien_q));
    end
    assign irq_n = irq_q;

    // Host read multiplexer, silent while the port is disabled
    always_comb begin
        reg_rdata = '0;
        if (host_en) begin
            case (reg_addr)
                A_STAT:  reg_rdata = {3'b000, tinfo};
                A_FLAG:  reg_rdata = {6'b0, flg_q};
                A_IEN:   reg_rdata = {6'b0, ien_q};
                default: reg_rdata = 8'(tmo_q);
            endcase
        end
    end

    assert_wr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !host_en) |=> ($stable(ien_q) && $stable(tmo_q)));
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q[0] && !(wr_ok && reg_addr == A_FLAG)) |=> flg_q[0]);
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> host_en);
endmodule

// File: tb/pwr_arm_ctrl_test.sv
module pwr_arm_ctrl_test;
    localparam int CLK_HALF = 5;
    localparam int P = 8;
    localparam logic [31:0] DEF = 32'hA5C3_5A3C;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        test_at_por = 1;
    logic        st_fault = 0;
    logic        otp_rd;
    logic [1:0]  otp_addr;
    logic [12:0] otp_word = '0;
    logic [31:0] cfg_out;
    logic        host_en;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic        irq_n;
    logic        act = 0;
    logic        sleep = 0;
    logic        seq_mon, armed, slp_enter, slp_exit;

    int total = 0;
    int bad = 0;
    int n_enter = 0;
    int n_exit = 0;
    logic [12:0] mem [4];
    logic [7:0]  dat [4];

    always #CLK_HALF clk = ~clk;

    pwr_arm_ctrl uut (
        .clk(clk), .rst_n(rst_n), .test_at_por(test_at_por), .st_fault(st_fault),
        .otp_rd(otp_rd), .otp_addr(otp_addr), .otp_word(otp_word), .cfg_out(cfg_out),
        .host_en(host_en), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n), .act(act), .sleep(sleep),
        .seq_mon(seq_mon), .armed(armed), .slp_enter(slp_enter), .slp_exit(slp_exit)
    );

    // Store model: data returned the cycle after a read strobe
    always @(posedge clk) if (otp_rd) otp_word <= mem[otp_addr];

    // Pulse counters sampled away from the active edge
    always @(negedge clk) begin
        if (slp_enter) n_enter++;
        if (slp_exit)  n_exit++;
    end

    function automatic logic [12:0] enc(input logic [7:0] d);
        logic [12:0] c = '0;
        c[3] = d[0]; c[5] = d[1]; c[6] = d[2]; c[7] = d[3];
        c[9] = d[4]; c[10] = d[5]; c[11] = d[6]; c[12] = d[7];
        for (int k = 0; k < 4; k++) begin
            logic par = 1'b0;
            for (int p = 1; p < 13; p++)
                if (((p >> k) & 1) == 1 && p != (1 << k)) par ^= c[p];
            c[1 << k] = par;
        end
        c[0] = ^c[12:1];
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expv);
        total++;
        if (actual !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_host();
        int guard = 0;
        while (!host_en && guard < 500) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] r;
        int t;
        int e0, x0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) dat[i] = 8'($urandom);
        mem[0] = enc(dat[0]);
        mem[1] = enc(dat[1]) ^ (13'd1 << (1 + $urandom % 12));
        mem[2] = enc(dat[2]) ^ 13'b0_0000_1000_1000;
        mem[3] = enc(dat[3]) ^ 13'd1;

        wait_cyc(3);
        chk("R2 reset host_en", {31'b0, host_en}, 0);
        chk("R2 reset irq_n", {31'b0, irq_n}, 1);
        chk("R7 reset seq_mon", {31'b0, seq_mon}, 0);
        rst_n = 1;
        wait_cyc(3);
        st_fault = 1;
        @(negedge clk);
        st_fault = 0;
        wr(2'd2, 8'h03);
        wr(2'd3, 8'h09);
        chk("R2 host_en during load", {31'b0, host_en}, 0);
        #1 chk("R2 rdata during load", {24'b0, reg_rdata}, 0);
        wait_host();
        chk("R2 load finished", {31'b0, host_en}, 1);
        rd(2'd0, r); chk("R1 R4 status after test+ecc", {24'b0, r}, 32'h0F);
        rd(2'd1, r); chk("R5 flags after boot", {24'b0, r}, 32'h03);
        rd(2'd2, r); chk("R2 early enable write ignored", {24'b0, r}, 0);
        rd(2'd3, r); chk("R2 early timeout write ignored", {24'b0, r}, 4);
        chk("R3 word0 clean", {24'b0, cfg_out[7:0]}, {24'b0, dat[0]});
        chk("R3 word1 corrected", {24'b0, cfg_out[15:8]}, {24'b0, dat[1]});
        chk("R4 word2 default kept", {24'b0, cfg_out[23:16]}, {24'b0, DEF[23:16]});
        chk("R3 word3 parity-bit error", {24'b0, cfg_out[31:24]}, {24'b0, dat[3]});
        chk("R6 irq idle with no enable", {31'b0, irq_n}, 1);

        wr(2'd2, 8'h01); wait_cyc(1);
        chk("R6 irq on test flag", {31'b0, irq_n}, 0);
        wr(2'd1, 8'h01);
        rd(2'd1, r); chk("R5 w1c clears bit0 only", {24'b0, r}, 2);
        wait_cyc(1);
        chk("R6 irq released after clear", {31'b0, irq_n}, 1);
        wr(2'd2, 8'h02); wait_cyc(1);
        chk("R6 irq on ecc flag", {31'b0, irq_n}, 0);
        wr(2'd1, 8'h02); wait_cyc(2);
        chk("R6 irq released ecc", {31'b0, irq_n}, 1);

        // Directed: sleep edges during timing are ignored, then act when armed
        wr(2'd3, 8'd5);
        e0 = n_enter; x0 = n_exit;
        @(negedge clk); act = 1;
        wait_cyc(4);
        chk("R7 seq_mon after act rise", {31'b0, seq_mon}, 1);
        sleep = 1; wait_cyc(4); sleep = 0; wait_cyc(4);
        chk("R9 sleep ignored while timing", n_enter + n_exit - e0 - x0, 0);
        wait_cyc(40);
        chk("R7 armed after timeout", {31'b0, armed}, 1);
        chk("R7 seq_mon off when armed", {31'b0, seq_mon}, 0);
        sleep = 1; wait_cyc(5);
        chk("R9 entry pulse", n_enter - e0, 1);
        sleep = 0; wait_cyc(5);
        chk("R9 exit pulse", n_exit - x0, 1);
        act = 0; wait_cyc(5);
        chk("R9 act low leaves armed", {31'b0, armed}, 0);
        e0 = n_enter;
        sleep = 1; wait_cyc(5); sleep = 0; wait_cyc(5);
        chk("R9 sleep ignored when idle", n_enter - e0, 0);

        // Random timeout lengths checked against a window around expiry
        for (int it = 0; it < 5; it++) begin
            t = 1 + $urandom % 5;
            wr(2'd3, 8'(t));
            @(negedge clk); act = 1;
            wait_cyc(8 * t - 2);
            chk("R7 not armed before expiry", {31'b0, armed}, 0);
            wait_cyc(6);
            chk("R7 armed at expiry", {31'b0, armed}, 1);
            act = 0; wait_cyc(5);
        end

        // Timeout value 0 behaves as one tick
        wr(2'd3, 8'd0);
        @(negedge clk); act = 1;
        wait_cyc(5);
        chk("R7 zero timeout not yet", {31'b0, armed}, 0);
        wait_cyc(7);
        chk("R7 zero timeout one tick", {31'b0, armed}, 1);
        act = 0; wait_cyc(5);

        // Cancel by ACT falling early
        wr(2'd3, 8'd6);
        @(negedge clk); act = 1;
        wait_cyc(20);
        chk("R8 timer running", {31'b0, seq_mon}, 1);
        act = 0; wait_cyc(5);
        chk("R8 cancelled seq_mon", {31'b0, seq_mon}, 0);
        wait_cyc(60);
        chk("R8 never armed", {31'b0, armed}, 0);
        @(negedge clk); act = 1;
        wait_cyc(4);
        chk("R8 restart on next rise", {31'b0, seq_mon}, 1);
        act = 0; wait_cyc(5);

        // Second start-up: self-test skipped, clean words
        rst_n = 0; test_at_por = 0;
        for (int i = 0; i < 4; i++) begin
            dat[i] = 8'($urandom);
            mem[i] = enc(dat[i]);
        end
        wait_cyc(3);
        rst_n = 1;
        wait_host();
        rd(2'd0, r); chk("R1 status when skipped", {24'b0, r}, 32'h10);
        rd(2'd1, r); chk("R5 no flags when skipped", {24'b0, r}, 0);
        chk("R3 clean load all words", cfg_out, {dat[3], dat[2], dat[1], dat[0]});
        chk("R7 idle after reboot", {31'b0, armed}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule